// File: doc/BRIEF.md
# Push-Button Power Sequencing Controller

This block decides when a small power system is on. A user push-button (active low) or a power-hold level from the host processor (active high) can start the system. A button start turns on all four regulator channels. It also keeps the processor reset pin pulled low for a fixed number of timer ticks, nominally 260 ticks of 1 ms. After that the reset pin is released to high impedance. A hold-only start skips the reset interval and leaves channel 3 off.

After a button start, the processor must raise power-hold before the button is let go, or the system drops back to off. While running, a button press pulls the interrupt line low so that software can decide whether to shut down. The system powers off only when power-hold is removed while the button is up. Both inputs pass through a two-stage synchronizer, so an input change takes three clock edges to reach the outputs. The block has no data stream, so all of its pins are plain control levels.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While reset is active, and right after it, `rail_en` is 4'b0000, `rst_oe` is 1 (reset pin pulled low) and `irq_n` is 1.
- R2: A low on `btn_n` while off starts the system with all four channels enabled. `rail_en[0]` is channel 1 and `rail_en[3]` is channel 4, so the value is 4'b1111.
- R3: A high on `pwr_hold` while off, with the button up, starts the system with channels 1, 2 and 4 only (`rail_en` = 4'b1011). `rst_oe` drops to 0 at the same time.
- R4: After a button start, `rst_oe` stays 1 for exactly RESET_TICKS cycles in which `tick` is high, then goes to 0. Cycles with `tick` low do not advance the interval.
- R5: If the button is released while `pwr_hold` is low, before the system has latched on, all rails switch off and `rst_oe` returns to 1.
- R6: If the button is released while `pwr_hold` is high, after the reset interval, the system keeps its rails on with `rst_oe` at 0.
- R7: While running, a low on `btn_n` drives `irq_n` low. `irq_n` returns high when the button is released. A press does not change the rails.
- R8: While running, a low on `pwr_hold` with the button up switches off every rail and sets `rst_oe` to 1. While the button is held down, a low on `pwr_hold` leaves the rails on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Clock-enable pulse that paces the reset interval |
| btn_n | input | 1 | Push-button, low when pressed (asynchronous) |
| pwr_hold | input | 1 | Power-hold from the processor, high to stay on (asynchronous) |
| rail_en | output | 4 | Regulator enables; bit 0 is channel 1 |
| rst_oe | output | 1 | Drive-enable of the open-drain processor reset; 1 pulls the pin low |
| irq_n | output | 1 | Active-low interrupt reporting a button press while running |

## Verification
The hardest situations to reach are the ones that depend on timing against the reset interval. One is a release of the button while the reset timer is still counting. Another is a release with hold low after the timer has expired. A third is a run of paused ticks in the middle of the interval. The stimulus reaches these by driving the button on a known falling edge and then counting clock edges. It counts the three synchronizer and state stages, plus the tick count, so that each release lands in a known state. A separate pass gates `tick` off entirely to show that the interval holds, and then lets it finish.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [2:0] {
    S_OFF        = 3'd0,
    S_RESET_HOLD = 3'd1,
    S_WAIT_HOLD  = 3'd2,
    S_RUN        = 3'd3,
    S_SHUTDOWN   = 3'd4
  } seq_state_t;

  localparam int NUM_RAILS = 4;
  // channel 3 is only enabled after a button start
  localparam int BTN_ONLY_IDX = 2;
endpackage

// File: rtl/pwr_seq_sync.sv
module pwr_seq_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
  parameter int TICKS = 260
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic done
);
  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt;

  assign done = run && tick && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= done ? '0 : cnt + 1'b1;
  end

  // R4: count never runs past the final tick
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  // R4: a cycle without tick leaves the interval where it was
  a_r4_cnt_pause: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(tick)) |-> $stable(cnt));
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 btn_low,
  input  logic                 hold_on,
  input  logic                 tmr_done,
  output seq_state_t           state,
  output logic [NUM_RAILS-1:0] rail_en,
  output logic                 rst_oe,
  output logic                 irq_n
);
  seq_state_t nxt;
  logic       btn_start;
  logic       powered;

  always_comb begin
    nxt = state;
    unique case (state)
      S_OFF: begin
        if (btn_low)      nxt = S_RESET_HOLD;
        else if (hold_on) nxt = S_RUN;
      end
      S_RESET_HOLD: begin
        if (tmr_done)                nxt = S_WAIT_HOLD;
        else if (!btn_low && !hold_on) nxt = S_OFF;
      end
      S_WAIT_HOLD: begin
        if (!btn_low) nxt = hold_on ? S_RUN : S_OFF;
      end
      S_RUN: begin
        if (!hold_on && !btn_low) nxt = S_SHUTDOWN;
      end
      S_SHUTDOWN: nxt = S_OFF;
      default:    nxt = S_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_OFF;
      btn_start <= 1'b0;
    end else begin
      state <= nxt;
      if (state == S_OFF) btn_start <= btn_low;
    end
  end

  assign powered = (state == S_RESET_HOLD) || (state == S_WAIT_HOLD) || (state == S_RUN);

  for (genvar i = 0; i < NUM_RAILS; i++) begin : g_rail
    if (i == BTN_ONLY_IDX) begin : g_btn_only
      assign rail_en[i] = powered && btn_start;
    end else begin : g_common
      assign rail_en[i] = powered;
    end
  end

  assign rst_oe = !((state == S_RUN) || (state == S_WAIT_HOLD));
  assign irq_n  = !((state == S_RUN) && btn_low);

  // R8: shutdown is entered only from run with hold dropped and button up
  a_r8_shutdown_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SHUTDOWN) |-> ($past(state) == S_RUN && !$past(hold_on) && !$past(btn_low)));

  // R5: leaving the wait state towards off needs a release with hold low
  a_r5_wait_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_OFF && $past(state) == S_WAIT_HOLD) |-> (!$past(hold_on) && !$past(btn_low)));

  // R4: reset interval ends only on the timer's final tick
  a_r4_interval_end: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT_HOLD && $past(state) == S_RESET_HOLD) |-> $past(tmr_done));

  // R2: the channel-3 choice is frozen while powered
  a_r2_btn_start_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_OFF && $past(state) != S_OFF) |-> $stable(btn_start));
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int RESET_TICKS = 260,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       btn_n,
  input  logic       pwr_hold,
  output logic [3:0] rail_en,
  output logic       rst_oe,
  output logic       irq_n
);
  localparam int NUM_IN = 2;
  // idle levels: bit 0 button (released = 1), bit 1 hold (low = 0)
  localparam logic [NUM_IN-1:0] IN_IDLE = 2'b01;

  logic [NUM_IN-1:0] raw_in;
  logic [NUM_IN-1:0] sync_in;
  logic              btn_low;
  logic              hold_on;
  logic              tmr_done;
  seq_state_t        state;

  assign raw_in = {pwr_hold, btn_n};

  for (genvar g = 0; g < NUM_IN; g++) begin : g_sync
    pwr_seq_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (IN_IDLE[g])
    ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in[g]),
      .q     (sync_in[g])
    );
  end

  assign btn_low = !sync_in[0];
  assign hold_on = sync_in[1];

  pwr_seq_timer #(
    .TICKS (RESET_TICKS)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state == S_RESET_HOLD),
    .tick  (tick),
    .done  (tmr_done)
  );

  pwr_seq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .btn_low  (btn_low),
    .hold_on  (hold_on),
    .tmr_done (tmr_done),
    .state    (state),
    .rail_en  (rail_en),
    .rst_oe   (rst_oe),
    .irq_n    (irq_n)
  );

  // R3: rails coming up without channel 3 means a hold-only start
  a_r3_hold_start: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rail_en[0]) && !rail_en[2]) |-> ($past(hold_on) && !$past(btn_low)));

  // R7: interrupt is only signalled with the rails up
  a_r7_irq_powered: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (rail_en[0] && !rst_oe));

  // R6: reset pin released only with all common rails on
  a_r6_release_rails: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_oe |-> (rail_en[0] && rail_en[1] && rail_en[3]));
endmodule

// File: tb/pwr_seq_ctrl_test.sv
module pwr_seq_ctrl_test;
  localparam int TICKS = 8;
  localparam int NV    = 14;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic       btn_n;
  logic       pwr_hold;
  logic [3:0] rail_en;
  logic       rst_oe;
  logic       irq_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pwr_seq_ctrl #(.RESET_TICKS(TICKS)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .btn_n(btn_n),
    .pwr_hold(pwr_hold), .rail_en(rail_en), .rst_oe(rst_oe), .irq_n(irq_n)
  );

  // {req[3:0], btn_n, hold, wait[4:0], rails[3:0], oe, irq_n}
  localparam logic [16:0] VEC [NV] = '{
    {4'd1, 1'b1, 1'b0, 5'd5,  4'b0000, 1'b1, 1'b1},
    {4'd2, 1'b0, 1'b0, 5'd4,  4'b1111, 1'b1, 1'b1},
    {4'd4, 1'b0, 1'b0, 5'd10, 4'b1111, 1'b0, 1'b1},
    {4'd6, 1'b0, 1'b1, 5'd4,  4'b1111, 1'b0, 1'b1},
    {4'd6, 1'b1, 1'b1, 5'd4,  4'b1111, 1'b0, 1'b1},
    {4'd7, 1'b0, 1'b1, 5'd4,  4'b1111, 1'b0, 1'b0},
    {4'd7, 1'b1, 1'b1, 5'd4,  4'b1111, 1'b0, 1'b1},
    {4'd8, 1'b1, 1'b0, 5'd5,  4'b0000, 1'b1, 1'b1},
    {4'd3, 1'b1, 1'b1, 5'd5,  4'b1011, 1'b0, 1'b1},
    {4'd7, 1'b0, 1'b1, 5'd4,  4'b1011, 1'b0, 1'b0},
    {4'd8, 1'b0, 1'b0, 5'd4,  4'b1011, 1'b0, 1'b0},
    {4'd8, 1'b1, 1'b0, 5'd5,  4'b0000, 1'b1, 1'b1},
    {4'd4, 1'b0, 1'b0, 5'd14, 4'b1111, 1'b0, 1'b1},
    {4'd5, 1'b1, 1'b0, 5'd5,  4'b0000, 1'b1, 1'b1}
  };

  function automatic string req_name(input logic [3:0] r);
    case (r)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [3:0] e_rail,
                       input logic e_oe, input logic e_irq);
    checks++;
    if (rail_en !== e_rail || rst_oe !== e_oe || irq_n !== e_irq) begin
      errors++;
      $display("FAIL %s: rails=%b oe=%b irq_n=%b expected rails=%b oe=%b irq_n=%b",
               req, rail_en, rst_oe, irq_n, e_rail, e_oe, e_irq);
    end
  endtask

  task automatic drive(input logic b, input logic h, input int cyc);
    btn_n = b;
    pwr_hold = h;
    repeat (cyc) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; tick = 1'b1; btn_n = 1'b1; pwr_hold = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", 4'b0000, 1'b1, 1'b1);          // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 4'b0000, 1'b1, 1'b1);          // R1 after release

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][12], VEC[i][11], int'(VEC[i][10:6]));
      check(req_name(VEC[i][16:13]), VEC[i][5:2], VEC[i][1], VEC[i][0]);
    end

    // R4: exact interval length in ticks
    begin
      int n = 0;
      btn_n = 1'b0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (rail_en != 4'b0000) break;
      end
      while (rst_oe === 1'b1 && rail_en != 4'b0000 && n < 40) begin
        n++;
        @(negedge clk);
      end
      checks++;
      if (n != TICKS) begin
        errors++;
        $display("FAIL R4: reset interval=%0d expected=%0d", n, TICKS);
      end
    end
    drive(1'b1, 1'b0, 5);
    check("R5", 4'b0000, 1'b1, 1'b1);          // R5 release from wait, hold low

    // R5: release inside the reset interval with hold low
    drive(1'b0, 1'b0, 5);
    check("R2", 4'b1111, 1'b1, 1'b1);
    drive(1'b1, 1'b0, 5);
    check("R5", 4'b0000, 1'b1, 1'b1);

    // R4: ticks paused keep the reset pin low
    tick = 1'b0;
    drive(1'b0, 1'b0, 30);
    check("R4", 4'b1111, 1'b1, 1'b1);
    tick = 1'b1;
    drive(1'b0, 1'b0, 12);
    check("R4", 4'b1111, 1'b0, 1'b1);
    drive(1'b1, 1'b0, 5);
    check("R5", 4'b0000, 1'b1, 1'b1);

    // R1: reset while running clears everything at once
    drive(1'b1, 1'b1, 5);
    check("R3", 4'b1011, 1'b0, 1'b1);
    rst_n = 1'b0;
    #1;
    check("R1", 4'b0000, 1'b1, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule